// File: doc/BRIEF.md
# Nibble-Addressed Double-Buffered DAC Code Latch

This block is the digital front end of a 12-bit parallel-input converter. A processor bus with eight data lines and two address lines builds a 12-bit code in a staging (input) latch. It can do this in three nibble writes, or in one byte write followed by one nibble write. A write is framed by active-low chip-select and write strobes. The staging latch takes its value when the combined strobe is released.

A separate active-low load strobe copies the whole staging word into the output (DAC) latch, which drives the code output. An active-low clear zeroes both latches and takes priority over a load. All strobes are asynchronous to the system clock. Each one passes through a two-flop synchroniser before it acts. The data, address and mode inputs must stay stable until the write has been captured.

The mode input sets which data lines feed the middle nibble. With mode low, the upper data lines are assumed to be tied to the lower ones, so the middle nibble is taken from the low four lines. With mode high, it is taken from the upper four lines.

Top module: `nibdac_if`

## Requirements
- R1: After reset, code_out is 12'h000.
- R2: A write with addr = 2'b10 replaces code bits 3:0 with data_in[3:0] and leaves the other bits as they were.
- R3: A write with addr = 2'b11 replaces code bits 11:8 with data_in[3:0] and leaves the other bits as they were.
- R4: A write with addr = 2'b01 replaces code bits 7:4. The source is data_in[3:0] when byte_mode = 0 and data_in[7:4] when byte_mode = 1.
- R5: A write with addr = 2'b00 replaces code bits 7:0 with data_in[7:0] in either mode.
- R6: The staging latch is written only when cs_n and wr_n have both been low together. It takes data_in, addr and byte_mode when that combined strobe is released. Driving either strobe low on its own changes nothing.
- R7: A staging write does not change code_out. A low level on ld_n copies the whole staging word to code_out whatever the state of cs_n. code_out shows the new word after the third rising clock edge following the fall of ld_n.
- R8: While ld_n is held low, code_out follows the staging latch, so a write captured during the load also reaches the output.
- R9: A low level on clr_n sets code_out and the staging latch to zero within three rising edges, even when ld_n is low at the same time. A later load therefore also gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 8 | Bus data lines |
| addr | input | 2 | Nibble select, {A1, A0} |
| byte_mode | input | 1 | 0: 4+4+4 loading, 1: 8+4 loading |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe (staging to output), active low, level sensitive |
| clr_n | input | 1 | Clear, active low, level sensitive |
| code_out | output | 12 | Code held in the output latch |

## Verification
A staging write is captured on the third rising edge after the combined strobe is released. A load or clear shows on code_out on the third rising edge after ld_n or clr_n falls. The bench therefore holds data and address for six cycles after each write and holds each load or clear for four cycles. It samples code_out on falling edges once those windows have closed. The output is compared once after each write and before its load, to show it has not moved. It is compared again after the load, against the word expected in the vector table.

// File: rtl/nibdac_pkg.sv
package nibdac_pkg;
  localparam int NIB_W   = 4;
  localparam int NIB_CNT = 3;
  localparam int CODE_W  = NIB_W * NIB_CNT;
  localparam int BUS_W   = 2 * NIB_W;

  typedef enum logic [1:0] {
    SEL_BYTE = 2'b00,
    SEL_MID  = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_HIGH = 2'b11
  } nib_sel_e;

  typedef logic [CODE_W-1:0] code_t;

  // Assemble the next staging word from the current one and one bus access.
  function automatic code_t merge_word(code_t cur, nib_sel_e sel,
                                       logic [BUS_W-1:0] bus, logic byte_mode);
    code_t nxt;
    logic [NIB_W-1:0] lo;
    logic [NIB_W-1:0] hi;
    nxt = cur;
    lo  = bus[NIB_W-1:0];
    hi  = bus[BUS_W-1:NIB_W];
    case (sel)
      SEL_LOW:  nxt[NIB_W-1:0]         = lo;
      SEL_MID:  nxt[2*NIB_W-1:NIB_W]   = byte_mode ? hi : lo;
      SEL_HIGH: nxt[CODE_W-1:2*NIB_W]  = lo;
      default:  nxt[BUS_W-1:0]         = bus;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/nibdac_sync.sv
module nibdac_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nibdac_strobe.sv
module nibdac_strobe #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic commit
);
  logic wr_act;
  logic wr_sync;
  logic wr_prev_q;

  assign wr_act = ~cs_n & ~wr_n;

  nibdac_sync #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (wr_act),
    .sync_out (wr_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_sync;
  end

  // Release of the combined strobe, seen after synchronisation.
  assign commit = wr_prev_q & ~wr_sync;

  // R6: capture is a single-cycle event per released strobe
  a_r6_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  a_r6_commit_after_active: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(wr_sync));
endmodule

// File: rtl/nibdac_input_latch.sv
module nibdac_input_latch
  import nibdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             clear,
  input  nib_sel_e         sel,
  input  logic [BUS_W-1:0] bus,
  input  logic             byte_mode,
  output code_t            word
);
  code_t word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (clear)  word_q <= '0;
    else if (commit) word_q <= merge_word(word_q, sel, bus, byte_mode);
  end

  assign word = word_q;

  // R6: without a capture event the staging word holds
  a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !clear) |=> $stable(word_q));
  // R9: clear empties the staging latch
  a_r9_stage_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word_q == '0));
endmodule

// File: rtl/nibdac_hold.sv
module nibdac_hold
  import nibdac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  logic  clr_en,
  input  code_t word_in,
  output code_t dac_word
);
  code_t dac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dac_q <= '0;
    else if (clr_en)  dac_q <= '0;
    else if (load_en) dac_q <= word_in;
  end

  assign dac_word = dac_q;

  // R7: output only moves under load or clear
  a_r7_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !clr_en) |=> $stable(dac_q));
  // R8: while load is active the output tracks the staging word
  a_r8_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !clr_en) |=> (dac_q == $past(word_in)));
  // R9: clear beats load
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (dac_q == '0));
endmodule

// File: rtl/nibdac_if.sv
module nibdac_if
  import nibdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  data_in,
  input  logic [1:0]        addr,
  input  logic              byte_mode,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  output logic [CODE_W-1:0] code_out
);
  logic  commit;
  logic  load_en;
  logic  clr_en;
  code_t stage_word;
  code_t dac_word;

  nibdac_strobe #(.STAGES(SYNC_STAGES)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .wr_n   (wr_n),
    .commit (commit)
  );

  nibdac_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (~ld_n),
    .sync_out (load_en)
  );

  nibdac_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (~clr_n),
    .sync_out (clr_en)
  );

  nibdac_input_latch u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .clear     (clr_en),
    .sel       (nib_sel_e'(addr)),
    .bus       (data_in),
    .byte_mode (byte_mode),
    .word      (stage_word)
  );

  nibdac_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .clr_en   (clr_en),
    .word_in  (stage_word),
    .dac_word (dac_word)
  );

  assign code_out = dac_word;

  // R1: reset leaves the output at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (code_out == '0));
endmodule

// File: tb/nibdac_if_bench.sv
module nibdac_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data_in = '0;
  logic [1:0]  addr = '0;
  logic        byte_mode = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        ld_n = 1'b1;
  logic        clr_n = 1'b1;
  logic [11:0] code_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibdac_if u_nibdac_if (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_in   (data_in),
    .addr      (addr),
    .byte_mode (byte_mode),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .ld_n      (ld_n),
    .clr_n     (clr_n),
    .code_out  (code_out)
  );

  // {byte_mode, addr, data, expected code after load}
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 2'b10, 8'h35, 12'h005},  // R2 low nibble
    {1'b0, 2'b11, 8'hA9, 12'h905},  // R3 high nibble
    {1'b0, 2'b01, 8'h7C, 12'h9C5},  // R4 middle from low lines
    {1'b1, 2'b01, 8'h7C, 12'h975},  // R4 middle from upper lines
    {1'b1, 2'b00, 8'hE2, 12'h9E2},  // R5 byte, 8+4 mode
    {1'b0, 2'b00, 8'h4B, 12'h94B},  // R5 byte, 4+4+4 mode
    {1'b1, 2'b11, 8'hF0, 12'h04B},  // R3 high nibble zero
    {1'b1, 2'b10, 8'h1D, 12'h04D}   // R2 low nibble
  };

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: code_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic m, logic [1:0] a, logic [7:0] d,
                          logic cs_low, logic wr_low);
    @(negedge clk);
    byte_mode = m; addr = a; data_in = d;
    cs_n = ~cs_low; wr_n = ~wr_low;
    repeat (3) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_load();
    @(negedge clk);
    ld_n = 1'b0;
    repeat (4) @(negedge clk);
    ld_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr_n = 1'b0;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [11:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset", code_out, 12'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", code_out, 12'h000);

    // Table walk: write, confirm output held, load, confirm word.
    for (int i = 0; i < 8; i++) begin
      prev = code_out;
      do_write(VEC[i][22], VEC[i][21:20], VEC[i][19:12], 1'b1, 1'b1);
      check("R7 held before load", code_out, prev);
      do_load();
      check("R2-5 table word", code_out, VEC[i][11:0]);
    end

    // R6: a single strobe low alone does not write
    do_write(1'b0, 2'b10, 8'h0A, 1'b1, 1'b0);
    do_write(1'b0, 2'b11, 8'h0B, 1'b0, 1'b1);
    do_load();
    check("R6 lone strobe ignored", code_out, 12'h04D);

    // R7: load works with cs_n held low (not writing) as well
    @(negedge clk);
    cs_n = 1'b0;
    do_write(1'b0, 2'b10, 8'h03, 1'b1, 1'b1);
    cs_n = 1'b0;
    do_load();
    cs_n = 1'b1;
    check("R7 load ignores cs_n", code_out, 12'h043);

    // R7 latency: output changes on third edge after ld_n falls
    do_write(1'b0, 2'b11, 8'h07, 1'b1, 1'b1);
    @(negedge clk);
    ld_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 not yet after two edges", code_out, 12'h043);
    @(negedge clk);
    check("R7 after third edge", code_out, 12'h743);
    ld_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: transparent while load held
    @(negedge clk);
    ld_n = 1'b0;
    do_write(1'b1, 2'b00, 8'h5A, 1'b1, 1'b1);
    check("R8 follows during load", code_out, 12'h75A);
    ld_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: clear zeroes output
    do_clear();
    check("R9 clear output", code_out, 12'h000);
    do_load();
    check("R9 stage cleared", code_out, 12'h000);

    // R9: clear together with load
    do_write(1'b0, 2'b11, 8'h0C, 1'b1, 1'b1);
    @(negedge clk);
    clr_n = 1'b0; ld_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 clear beats load", code_out, 12'h000);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 no stale after clear", code_out, 12'h000);
    ld_n = 1'b1;
    repeat (2) @(negedge clk);

    // Normal operation resumes
    do_write(1'b1, 2'b01, 8'h80, 1'b1, 1'b1);
    do_load();
    check("R4 after clear", code_out, 12'h080);

    finish_run();
  end
endmodule